// File: doc/BRIEF.md
# Block Minimum, Maximum and Mean Unit

This unit holds a bank of 32 unsigned words, each `DW` bits wide, which is filled through a simple write port. After a start pulse it reads the bank once, from index 0 up to index 31. During that pass it records the smallest word and the largest word, and it accumulates the sum. The mean is the sum divided by 32, formed with a right shift. The unit is built as a datapath with a separate finite-state controller. A two-bit selector chooses which result appears on the result port. The finish flag stays high until the next start.

The controller has four states. In IDLE it waits for `go`. INIT clears the statistics and issues the read of word 0. SCAN takes in one word per cycle, because the read is synchronous and each word arrives one cycle after its address. FIN raises `done`. The transitions are IDLE to INIT on `go`, INIT to SCAN always, SCAN to SCAN while the index is below 31, SCAN to FIN at index 31, FIN to INIT on `go`, and FIN holding otherwise.

Top module: `mma_calc`

## Requirements
- R1: When `ld_en` is high at a rising clock edge, `ld_data` is stored at bank index `ld_addr`. A later scan uses that stored value.
- R2: While `rst_n` is low, and after it is released, `done` is 0 and every `sel` code reads 0 on `result`.
- R3: `go` is sampled in IDLE or FIN and starts a scan. `done` first reads 1 after the 34th rising edge, counting the edge that sampled `go` as the first.
- R4: The minimum starts at all ones. It is replaced only by a word strictly smaller than itself, so after a scan it equals the smallest of the 32 words.
- R5: The maximum starts at 0. It is replaced only by a word strictly larger than itself, so after a scan it equals the largest of the 32 words.
- R6: The sum is kept in DW+5 bits and cannot overflow. The mean equals floor(sum/32).
- R7: `sel` encoding: 0 shows the minimum, 1 shows the maximum, 2 shows the mean, and 3 shows 0.
- R8: `done` stays 1 while no `go` arrives. It reads 0 after the edge that samples a new `go`.
- R9: A `go` that arrives during INIT or SCAN has no effect. The scan length and the results are unchanged.
- R10: Each scan starts from fresh initial values. Results from an earlier scan do not leak into the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_data | input | DW | Word to store |
| ld_addr | input | 5 | Bank index for the store |
| ld_en | input | 1 | Store strobe |
| go | input | 1 | Start pulse |
| done | output | 1 | Results ready |
| sel | input | 2 | Result selector (0 min, 1 max, 2 mean, 3 zero) |
| result | output | DW | Selected result |

## Verification
The bench targets these corner cases:
- **All words zero and all words at full scale.** These expose a compare that is not strict or has the wrong initial value. Such a design would report all ones as the minimum, or 0 as the maximum.
- **Extreme value only at index 0 or only at index 31.** These catch an off-by-one in the read pipeline. Such a design would drop the first word or the last word, or count one word twice.
- **Full-scale sums.** A narrow accumulator would return a wrapped mean.
- **A second start during the scan.** A controller that restarts would finish late.
- **A repeated run after an extreme data set.** A missed clear would keep the old minimum or maximum.

// File: rtl/mma_pkg.sv
package mma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_SCAN = 2'd2,
        ST_FIN  = 2'd3
    } mma_state_e;

    typedef enum logic [1:0] {
        SEL_MIN  = 2'd0,
        SEL_MAX  = 2'd1,
        SEL_MEAN = 2'd2,
        SEL_NONE = 2'd3
    } mma_sel_e;

endpackage

// File: rtl/mma_store.sv
module mma_store #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] bank [DEPTH];
    logic [DW-1:0] rd_q;

    // Write port: one word stored per strobed edge (R1).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            bank[wr_addr] <= wr_data;
        end
    end

    // Synchronous read: data follows the address by one cycle.
    always_ff @(posedge clk) begin
        rd_q <= bank[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/mma_stats.sv
module mma_stats #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          acc_en,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] min_v,
    output logic [DW-1:0] max_v,
    output logic [DW-1:0] mean_v
);
    localparam int SUM_W = DW + AW;

    logic [DW-1:0]    min_q, max_q;
    logic [SUM_W-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q <= '0;
            max_q <= '0;
            sum_q <= '0;
        end else if (clr) begin
            // Fresh start values for every scan (R4, R5, R10).
            min_q <= '1;
            max_q <= '0;
            sum_q <= '0;
        end else if (acc_en) begin
            // Strict compares (R4, R5).
            if (word < min_q) min_q <= word;
            if (word > max_q) max_q <= word;
            // The wide accumulator cannot overflow (R6).
            sum_q <= sum_q + SUM_W'(word);
        end
    end

    assign min_v  = min_q;
    assign max_v  = max_q;
    // Truncating division by the word count (R6).
    assign mean_v = sum_q[SUM_W-1:AW];
endmodule

// File: rtl/mma_ctrl.sv
module mma_ctrl
    import mma_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic [AW-1:0] rd_addr,
    output logic          clr,
    output logic          acc_en,
    output logic          done
);
    localparam logic [AW-1:0] LAST = AW'((1 << AW) - 1);

    mma_state_e    state_q;
    logic [AW-1:0] idx_q;

    // State register and scan index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_FIN: begin
                    if (go) begin
                        state_q <= ST_INIT;
                        idx_q   <= '0;
                    end
                end
                ST_INIT: begin
                    // Go is ignored here (R9).
                    state_q <= ST_SCAN;
                    idx_q   <= '0;
                end
                ST_SCAN: begin
                    // Go is ignored here too (R9).
                    if (idx_q == LAST) begin
                        state_q <= ST_FIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        rd_addr = '0;
        clr     = 1'b0;
        acc_en  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_INIT: begin
                clr     = 1'b1;
                rd_addr = '0;
            end
            ST_SCAN: begin
                acc_en  = 1'b1;
                rd_addr = idx_q + 1'b1;
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mma_calc.sv
module mma_calc
    import mma_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ld_data,
    input  logic [4:0]    ld_addr,
    input  logic          ld_en,
    input  logic          go,
    output logic          done,
    input  logic [1:0]    sel,
    output logic [DW-1:0] result
);
    localparam int AW = 5;

    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          clr, acc_en;
    logic [DW-1:0] min_v, max_v, mean_v;

    mma_store #(.DW(DW), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    mma_ctrl #(.AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .rd_addr (rd_addr),
        .clr     (clr),
        .acc_en  (acc_en),
        .done    (done)
    );

    mma_stats #(.DW(DW), .AW(AW)) u_stats (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .acc_en (acc_en),
        .word   (rd_data),
        .min_v  (min_v),
        .max_v  (max_v),
        .mean_v (mean_v)
    );

    // Result selector (R7).
    always_comb begin
        unique case (mma_sel_e'(sel))
            SEL_MIN:  result = min_v;
            SEL_MAX:  result = max_v;
            SEL_MEAN: result = mean_v;
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/mma_calc_chk.sv
module mma_calc_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          go,
    input logic          done,
    input logic [1:0]    sel,
    input logic [DW-1:0] result,
    input logic          acc_en,
    input logic [DW-1:0] min_v,
    input logic [DW-1:0] max_v
);
    p_rst_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !done);

    p_min_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> (min_v <= $past(min_v)));

    p_max_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> (max_v >= $past(max_v)));

    p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (min_v <= max_v));

    p_sel_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd3) |-> (result == '0));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !go) |=> done);

    p_done_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go) |=> !done);

    p_scan_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> !done);
endmodule

bind mma_calc mma_calc_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .done   (done),
    .sel    (sel),
    .result (result),
    .acc_en (acc_en),
    .min_v  (min_v),
    .max_v  (max_v)
);

// File: tb/mma_calc_test.sv
module mma_calc_test;
    localparam int DW    = 8;
    localparam int NVEC  = 8;
    localparam int LAT   = 34;
    localparam int KIND [NVEC] = '{0, 0, 1, 2, 3, 4, 5, 2};
    localparam int SEED [NVEC] = '{0, 255, 3, 7, 0, 17, 200, 91};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] ld_data = '0;
    logic [4:0]    ld_addr = '0;
    logic          ld_en = 1'b0;
    logic          go = 1'b0;
    logic          done;
    logic [1:0]    sel = '0;
    logic [DW-1:0] result;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    int e_min, e_max, e_mean;

    always #5 clk = ~clk;

    mma_calc #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ld_data(ld_data), .ld_addr(ld_addr),
        .ld_en(ld_en), .go(go), .done(done), .sel(sel), .result(result)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pat(input int k, input int s, input int i);
        case (k)
            0: return s;
            1: return (i * 8 + s) % 256;
            2: return ((i * 37 + s * 13) ^ (i << 3)) % 256;
            3: return 255 - i;
            4: return (i == 31) ? s : 255;
            default: return (i == 0) ? s : 0;
        endcase
    endfunction

    task automatic load(input int k, input int s);
        int sum;
        e_min = 255; e_max = 0; sum = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 5'(i); ld_data = 8'(pat(k, s, i));
            if (pat(k, s, i) < e_min) e_min = pat(k, s, i);
            if (pat(k, s, i) > e_max) e_max = pat(k, s, i);
            sum += pat(k, s, i);
        end
        @(negedge clk);
        ld_en = 1'b0;
        e_mean = sum / 32;
    endtask

    // Pulse go; optional extra go at negedge number extra_at.
    task automatic run_scan(input int extra_at, output int lat, output int first_done);
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        lat = 1;
        first_done = int'(done);
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            go = (lat == extra_at);
        end
        go = 1'b0;
    endtask

    task automatic read_all(input string tag);
        sel = 2'd0; #1; check({"R4 min ", tag}, int'(result), e_min);
        sel = 2'd1; #1; check({"R5 max ", tag}, int'(result), e_max);
        sel = 2'd2; #1; check({"R6 mean ", tag}, int'(result), e_mean);
        sel = 2'd3; #1; check({"R7 sel3 ", tag}, int'(result), 0);
    endtask

    initial begin
        int lat, fd;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 done after reset", int'(done), 0);
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s); #1;
            check("R2 result after reset", int'(result), 0);
        end

        // Vector table walk (R1, R3..R7, R10)
        for (int v = 0; v < NVEC; v++) begin
            load(KIND[v], SEED[v]);
            run_scan(0, lat, fd);
            check($sformatf("R3 latency vec%0d", v), lat, LAT);
            if (v > 0) check("R8 done drops after go", fd, 0);
            read_all($sformatf("R1 R10 vec%0d", v));
        end

        // R8: done holds without go
        repeat (6) @(negedge clk);
        check("R8 done held", int'(done), 1);

        // R9: go during scan ignored
        load(2, 44);
        run_scan(12, lat, fd);
        check("R9 latency with extra go", lat, LAT);
        read_all("R9");
        repeat (3) @(negedge clk);
        check("R9 no restart", int'(done), 1);

        // R1: overwrite one word, re-run
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 5'd17; ld_data = 8'd0;
        @(negedge clk);
        ld_en = 1'b0;
        e_min = 0;
        e_mean = 0;
        for (int i = 0; i < 32; i++) e_mean += (i == 17) ? 0 : pat(2, 44, i);
        e_mean = e_mean / 32;
        e_max = 0;
        for (int i = 0; i < 32; i++)
            if (i != 17 && pat(2, 44, i) > e_max) e_max = pat(2, 44, i);
        run_scan(0, lat, fd);
        check("R3 latency rerun", lat, LAT);
        read_all("R1 overwrite");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule